// File: doc/BRIEF.md
# Accumulator Fetch-Execute Controller

A small multi-cycle processor core that runs programs out of one read-write memory. The same memory holds code and data. The core carries every instruction through explicit register transfers. The program counter goes into the memory address register. A memory read fills the memory data register. That word moves into the instruction register, and only then is the program counter stepped. Decode settles jumps at once. Every other instruction works on a single accumulator, and operands and results travel through the same address and data registers.

The core attaches to one synchronous single-port memory. It presents an address and write data and raises a write enable, and it receives read data one clock after the address was presented. The accumulator, the program counter and a halt flag are brought out for observation. Instructions are one word wide: a 3-bit opcode in the top bits and an address field of `ADDR_W` bits below it.

Top module: `acc_fetch_core`

## Requirements
- R1: While `rst_ni` is low, asynchronously, the program counter, accumulator, address, data and instruction registers are all zero, `mem_we_o` and `halted_o` are low, and the core leaves reset in the first fetch step.
- R2: An instruction word is `{opcode[2:0], addr[ADDR_W-1:0]}`. The opcodes are LOAD=0, STORE=1, ADD=2, SUB=3, JUMP=4, JUMP-IF-ZERO=5, HALT=6 and NOP=7.
- R3: The fetch runs in this order. The PC is copied to the address register, so `mem_addr_o` equals the PC one clock later. Memory is read into the data register, then the data register is copied into the instruction register. The PC then increments by one, and the incremented PC is visible after the fifth clock of the instruction. A sixth clock decodes the instruction.
- R4: The memory is read synchronously. The core holds the address for one clock and captures `mem_rdata_i` on the following clock.
- R5: LOAD, ADD and SUB first load the address field into the address register. They then read the operand through the data register and update the accumulator to the operand, to acc+operand or to acc-operand, modulo 2^8. Each takes 10 clocks.
- R6: STORE places the accumulator in the data register and writes it to the address field. `mem_we_o` is high for exactly one clock, and `mem_wdata_o` and `mem_addr_o` are valid during that clock. The accumulator is unchanged and the instruction takes 8 clocks.
- R7: JUMP loads its address field into the PC during decode and goes back to the first fetch step without an execute stage. It takes 6 clocks.
- R8: JUMP-IF-ZERO jumps like JUMP when the accumulator is zero. Otherwise the PC keeps its incremented value. It takes 6 clocks either way.
- R9: NOP changes neither the accumulator nor memory and takes 6 clocks.
- R10: HALT raises `halted_o` after its decode clock. From then until reset the PC stays at the HALT address plus one, the accumulator is held and no memory write occurs.
- R11: The PC is `ADDR_W` bits wide and wraps from the last address to 0 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | ADDR_W | Memory address (address register) |
| mem_wdata_o | output | ADDR_W+3 | Memory write data (data register) |
| mem_rdata_i | input | ADDR_W+3 | Memory read data, one clock after address |
| mem_we_o | output | 1 | Memory write enable |
| acc_o | output | ADDR_W+3 | Accumulator value |
| pc_o | output | ADDR_W | Program counter value |
| halted_o | output | 1 | High once HALT has been decoded |

## Verification
The bench builds the core with the default `ADDR_W` of 5, which gives 8-bit words and a 32-word memory. At that size a two-instruction program reaches the top address and makes the PC wrap. A one-byte accumulator also overflows and underflows with small operands, so both modulo cases are checked against hand-computed sums. Cycle counts to the halt are tied to the per-opcode latencies. They expose any stage that is added, dropped or reordered.

// File: rtl/fe_pkg.sv
package fe_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_JMP   = 3'd4,
    OP_JZ    = 3'd5,
    OP_HALT  = 3'd6,
    OP_NOP   = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    ST_PC2MAR,
    ST_FRD,
    ST_FMDR,
    ST_CIR,
    ST_INC,
    ST_DEC,
    ST_OPA,
    ST_ORD,
    ST_OMDR,
    ST_EXEC,
    ST_WR,
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic cir_ld;
    logic pc_inc;
    logic pc_jump;
    logic acc_ld;
    logic mem_we;
  } ctl_t;

endpackage

// File: rtl/fe_alu.sv
module fe_alu
  import fe_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = b_i;
    endcase
  end

endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  opcode_e opcode_i,
  input  logic    acc_zero_i,
  output state_e  state_o,
  output ctl_t    ctl_o,
  output alu_op_e alu_op_o
);

  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PC2MAR;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ctl_o   = '0;
    unique case (state_q)
      ST_PC2MAR: begin
        ctl_o.mar_from_pc = 1'b1;
        state_d = ST_FRD;
      end
      ST_FRD:  state_d = ST_FMDR;
      ST_FMDR: begin
        ctl_o.mdr_from_mem = 1'b1;
        state_d = ST_CIR;
      end
      ST_CIR: begin
        ctl_o.cir_ld = 1'b1;
        state_d = ST_INC;
      end
      ST_INC: begin
        ctl_o.pc_inc = 1'b1;
        state_d = ST_DEC;
      end
      ST_DEC: begin
        unique case (opcode_i)
          OP_JMP: begin
            ctl_o.pc_jump = 1'b1;
            state_d = ST_PC2MAR;
          end
          OP_JZ: begin
            ctl_o.pc_jump = acc_zero_i;
            state_d = ST_PC2MAR;
          end
          OP_HALT: state_d = ST_HALT;
          OP_NOP:  state_d = ST_PC2MAR;
          default: state_d = ST_OPA;
        endcase
      end
      ST_OPA: begin
        ctl_o.mar_from_ir = 1'b1;
        if (opcode_i == OP_STORE) begin
          ctl_o.mdr_from_acc = 1'b1;
          state_d = ST_WR;
        end else begin
          state_d = ST_ORD;
        end
      end
      ST_ORD:  state_d = ST_OMDR;
      ST_OMDR: begin
        ctl_o.mdr_from_mem = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        ctl_o.acc_ld = 1'b1;
        state_d = ST_PC2MAR;
      end
      ST_WR: begin
        ctl_o.mem_we = 1'b1;
        state_d = ST_PC2MAR;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_PC2MAR;
    endcase
  end

  always_comb begin
    unique case (opcode_i)
      OP_ADD:  alu_op_o = ALU_ADD;
      OP_SUB:  alu_op_o = ALU_SUB;
      default: alu_op_o = ALU_PASS;
    endcase
  end

  assign state_o = state_q;

  // R10
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> state_q == ST_HALT);

  // R6
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.mem_we |=> !ctl_o.mem_we);

  // R3
  fetch_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CIR |=> state_q == ST_INC && $past(state_q, 2) == ST_FMDR);

endmodule

// File: rtl/fe_regs.sv
module fe_regs
  import fe_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = ADDR_W + OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [WORD_W-1:0] alu_y_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [WORD_W-1:0] mdr_o,
  output logic [WORD_W-1:0] cir_o,
  output logic [WORD_W-1:0] acc_o
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] mdr_q, cir_q, acc_q;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_addr = cir_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pc_q <= '0;
    else if (ctl_i.pc_jump)    pc_q <= ir_addr;
    else if (ctl_i.pc_inc)     pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mar_q <= '0;
    else if (ctl_i.mar_from_pc)  mar_q <= pc_q;
    else if (ctl_i.mar_from_ir)  mar_q <= ir_addr;
  end

  // all memory traffic passes through the data register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mdr_q <= '0;
    else if (ctl_i.mdr_from_mem) mdr_q <= mem_rdata_i;
    else if (ctl_i.mdr_from_acc) mdr_q <= acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cir_q <= '0;
    else if (ctl_i.cir_ld) cir_q <= mdr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_q <= '0;
    else if (ctl_i.acc_ld) acc_q <= alu_y_i;
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign cir_o = cir_q;
  assign acc_o = acc_q;

  // R3 R7 R11
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pc_q == $past(pc_q)) || (pc_q == ADDR_W'($past(pc_q) + 1'b1))
             || (pc_q == $past(ir_addr)));

  // R4
  mdr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.mdr_from_mem |=> mdr_q == $past(mem_rdata_i));

endmodule

// File: rtl/acc_fetch_core.sv
module acc_fetch_core
  import fe_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int WORD_W = ADDR_W + OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o
);

  state_e            state;
  ctl_t              ctl;
  alu_op_e           alu_op;
  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] mdr, cir, acc, alu_y;
  opcode_e           opcode;

  assign opcode = opcode_e'(cir[WORD_W-1:ADDR_W]);

  fe_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opcode_i   (opcode),
    .acc_zero_i (acc == '0),
    .state_o    (state),
    .ctl_o      (ctl),
    .alu_op_o   (alu_op)
  );

  fe_regs #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .mem_rdata_i (mem_rdata_i),
    .alu_y_i     (alu_y),
    .pc_o        (pc),
    .mar_o       (mar),
    .mdr_o       (mdr),
    .cir_o       (cir),
    .acc_o       (acc)
  );

  fe_alu #(
    .W (WORD_W)
  ) u_alu (
    .a_i  (acc),
    .b_i  (mdr),
    .op_i (alu_op),
    .y_o  (alu_y)
  );

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mdr;
  assign mem_we_o    = ctl.mem_we;
  assign acc_o       = acc;
  assign pc_o        = pc;
  assign halted_o    = (state == ST_HALT);

  // R3
  mar_from_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_PC2MAR |=> mem_addr_o == $past(pc_o));

  // R5 R9 R10
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != ST_EXEC |=> $stable(acc_o));

  // R7
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DEC && opcode == OP_JMP) |=> pc_o == $past(cir[ADDR_W-1:0]));

  // R6
  store_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o == acc_o);

  // R10
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o && $stable(pc_o));

endmodule

// File: tb/acc_fetch_core_tb_top.sv
`timescale 1ns/1ps
module acc_fetch_core_tb_top;

  localparam int AW = 5;
  localparam int WW = AW + 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata, mem_rdata, acc;
  logic          mem_we, halted;
  logic [AW-1:0] pc;

  logic [WW-1:0] mem [DEPTH];
  int wr_cnt;
  int last_wa;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  acc_fetch_core #(.ADDR_W(AW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_we_o    (mem_we),
    .acc_o       (acc),
    .pc_o        (pc),
    .halted_o    (halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
      last_wa <= int'(mem_addr);
    end
    mem_rdata <= mem[mem_addr];
  end

  function automatic logic [WW-1:0] ins(input int op, input int a);
    return {op[2:0], a[AW-1:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst_ni = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = ins(6, 0);
    wr_cnt  = 0;
    last_wa = -1;
  endtask

  task automatic release_rst();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic step(inout int n);
    @(posedge clk);
    n++;
    @(negedge clk);
  endtask

  task automatic run_to_halt(inout int n);
    while (!halted && n < 3000) step(n);
  endtask

  // R1 R3 R9 R10
  task automatic t_reset();
    int n = 0;
    clear_mem();
    mem[0] = ins(7, 0);
    mem[1] = ins(6, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", int'(pc), 0);
    chk("R1 acc", int'(acc), 0);
    chk("R1 we", int'(mem_we), 0);
    chk("R1 halted", int'(halted), 0);
    rst_ni = 1'b1;
    step(n);
    chk("R3 addr=pc", int'(mem_addr), 0);
    repeat (3) step(n);
    chk("R3 pc before inc", int'(pc), 0);
    step(n);
    chk("R3 pc after inc", int'(pc), 1);
    run_to_halt(n);
    chk("R9 R10 cycles nop+halt", n, 12);
    chk("R10 pc", int'(pc), 2);
    chk("R9 acc", int'(acc), 0);
    // asynchronous clear mid-run
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async halted", int'(halted), 0);
    chk("R1 async pc", int'(pc), 0);
  endtask

  // R2 R4 R5 R6 R10
  task automatic t_arith();
    int n = 0;
    int pc_h, acc_h, wr_h;
    clear_mem();
    mem[0] = ins(0, 20);
    mem[1] = ins(2, 21);
    mem[2] = ins(3, 22);
    mem[3] = ins(1, 23);
    mem[4] = ins(6, 0);
    mem[20] = 8'd5;
    mem[21] = 8'd7;
    mem[22] = 8'd3;
    mem[23] = 8'hEE;
    release_rst();
    repeat (9) step(n);
    chk("R5 acc before exec", int'(acc), 0);
    step(n);
    chk("R5 load after 10", int'(acc), 5);
    run_to_halt(n);
    chk("R5 R6 cycles", n, 44);
    chk("R5 acc", int'(acc), 9);
    chk("R6 stored", int'(mem[23]), 9);
    chk("R6 write count", wr_cnt, 1);
    chk("R6 write addr", last_wa, 23);
    chk("R10 pc", int'(pc), 5);
    pc_h = int'(pc); acc_h = int'(acc); wr_h = wr_cnt;
    repeat (25) step(n);
    chk("R10 halted held", int'(halted), 1);
    chk("R10 pc frozen", int'(pc), pc_h);
    chk("R10 acc frozen", int'(acc), acc_h);
    chk("R10 no writes", wr_cnt, wr_h);
  endtask

  // R5 R6 R9
  task automatic t_wrap_arith();
    int n = 0;
    clear_mem();
    mem[0] = ins(0, 20);
    mem[1] = ins(2, 21);
    mem[2] = ins(1, 24);
    mem[3] = ins(7, 0);
    mem[4] = ins(3, 22);
    mem[5] = ins(1, 25);
    mem[6] = ins(6, 0);
    mem[20] = 8'hF0;
    mem[21] = 8'h20;
    mem[22] = 8'h30;
    release_rst();
    run_to_halt(n);
    chk("R5 R6 R9 cycles", n, 58);
    chk("R5 overflow", int'(mem[24]), 'h10);
    chk("R5 underflow", int'(mem[25]), 'hE0);
    chk("R6 acc kept", int'(acc), 'hE0);
    chk("R6 writes", wr_cnt, 2);
  endtask

  // R7 R8
  task automatic t_jump();
    int n = 0;
    clear_mem();
    mem[0] = ins(4, 3);
    mem[1] = ins(0, 20);
    mem[3] = ins(0, 21);
    mem[4] = ins(5, 7);
    mem[5] = ins(3, 21);
    mem[6] = ins(5, 8);
    mem[7] = ins(0, 20);
    mem[8] = ins(1, 22);
    mem[9] = ins(6, 0);
    mem[20] = 8'h55;
    mem[21] = 8'd6;
    mem[22] = 8'hAA;
    release_rst();
    repeat (6) step(n);
    chk("R7 jump target", int'(pc), 3);
    chk("R7 no exec", int'(acc), 0);
    run_to_halt(n);
    chk("R7 R8 cycles", n, 52);
    chk("R8 acc", int'(acc), 0);
    chk("R8 stored zero", int'(mem[22]), 0);
    chk("R8 pc", int'(pc), 10);
  endtask

  // R8 R11
  task automatic t_pc_wrap();
    int n = 0;
    clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] = ins(7, 0);
    mem[0]  = ins(5, 30);
    mem[31] = ins(6, 0);
    release_rst();
    run_to_halt(n);
    chk("R8 taken on zero cycles", n, 18);
    chk("R11 pc wrapped", int'(pc), 0);
    chk("R11 halted", int'(halted), 1);
  endtask

  initial begin
    #600000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_wrap_arith();
    t_jump();
    t_pc_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule